// File: doc/BRIEF.md
# Security-Banked System Handler Status Register

This block is a 32-bit memory-mapped register. It holds the active, pending and enable flags of the system exception handlers for a processor that has two security states. Every register access carries a secure or non-secure attribute. Most handler flags are stored twice, once per security state, and the attribute of the access picks which copy is read or written. A few flags have a single copy. Of these, some are visible only to secure accesses, some become visible to non-secure accesses only when a routing control input is set, and one is visible to every access.

Two flags, the non-secure hard-fault active flag and the NMI active flag, cannot be set by software. They can only be cleared, and only under a narrow set of conditions. These flags, and the secure hard-fault active flag, are set by the exception-entry logic through the `entry_mark` input. Every stored flag is driven out in parallel so that the prioritisation logic can use it. After every write the block raises a one-cycle pulse that tells the prioritisation logic to recompute. The `LEGACY` parameter builds the register for a processor without the security extension. In that build the hard-fault and NMI flags are not present.

Top module: `hsr_banked_status`

## Requirements
- R1: Reset (synchronous, active high) clears every stored flag and the update pulse. A read after reset returns 0.
- R2: Banked flags are stored once per security state. A secure access reads and writes the secure copy and a non-secure access uses the non-secure copy. A write to one copy never changes the other copy. Banked read positions: memory-manage active 0, hard-fault active 2, usage-fault active 3, supervisor-call active 7, pendable-service active 10, system-tick active 11, usage-fault pending 12, memory-manage pending 13, supervisor-call pending 15, memory-manage enable 16, usage-fault enable 18, hard-fault pending 21. With no write and no entry mark, all state holds.
- R3: The secure-fault active (bit 4), enable (bit 19) and pending (bit 20) flags have a single copy. A non-secure access reads them as 0, and its writes to them have no effect.
- R4: The bus-fault active (1), pending (14) and enable (17) flags and the NMI active flag (5) read as 0 unless the access is secure or `route_ns` is 1. The bus-fault flags are written only under that same condition.
- R5: A secure write never changes the secure hard-fault active flag, and it never changes the NMI active flag.
- R6: A write never sets the non-secure hard-fault active flag or the NMI active flag. Either flag is cleared only by a non-secure write that writes 0 to its bit while `cpu_secure` is 1 and `route_ns` is 1.
- R7: A non-secure write sets or clears the non-secure hard-fault pending flag (bit 21) directly.
- R8: The debug-monitor active flag (bit 8) has a single copy, and both secure and non-secure accesses read and write it.
- R9: A write updates the state on the clock edge that samples `wr_en`. `upd_pulse` is 1 for exactly the cycle after each write cycle.
- R10: `rdata` is combinational and valid in the same cycle as `rd_en`. It is 0 when `rd_en` is low, and the bits not listed in R2 to R8 always read 0.
- R11: The `entry_mark` input sets flags. Bit 0 sets the non-secure hard-fault active flag, bit 1 sets the secure hard-fault active flag, and bit 2 sets the NMI active flag, all on the next clock edge.
- R12: With `LEGACY` = 1, the hard-fault active flag (bit 2), the hard-fault pending flag (bit 21) and the NMI active flag (bit 5) read as 0 and cannot be changed by writes or entry marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| sec_access | input | 1 | Security attribute of the access (1 = secure) |
| cpu_secure | input | 1 | Processor is currently in secure state |
| route_ns | input | 1 | Routing control: bus-fault and NMI state is exposed to the non-secure side |
| wdata | input | 32 | Write data |
| entry_mark | input | 3 | Exception-entry set marks (bit 0 non-secure hard fault, bit 1 secure hard fault, bit 2 NMI) |
| rdata | output | 32 | Read data |
| upd_pulse | output | 1 | One-cycle pulse after a write |
| s_state | output | 12 | Secure banked flags |
| ns_state | output | 12 | Non-secure banked flags |
| shared_state | output | 8 | Single-copy flags |

## Verification
The assertions check the following on every cycle:
- Non-secure reads never expose the secure-fault flags.
- Bus-fault and NMI bits stay hidden while routing is off.
- A secure write leaves the secure hard-fault active flag alone.
- The two clear-only flags never rise without an entry mark.
- The update pulse follows the write strobe, and the state holds when nothing is written.
- `rdata` stays at 0 while no read strobe is present.

Only the bench scenarios can show the rest:
- The data path itself: that each field lands at its stated position in the selected bank.
- That the clear of the clear-only flags happens exactly when all four conditions meet.
- That the legacy build removes its three bits.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  localparam int WORD_W = 32;
  localparam int BANK_N = 12;
  localparam int SHR_N  = 8;
  localparam int MARK_N = 3;

  // Bit positions are software-visible and fixed.
  localparam int BANK_POS [BANK_N] = '{0, 2, 3, 7, 10, 11, 12, 13, 15, 16, 18, 21};
  localparam int SHR_POS  [SHR_N]  = '{1, 5, 4, 8, 14, 17, 19, 20};

  // Banked index names
  localparam int B_HF_ACT  = 1;
  localparam int B_HF_PEND = 11;

  // Shared index names
  localparam int S_BUS_ACT  = 0;
  localparam int S_NMI_ACT  = 1;
  localparam int S_SF_ACT   = 2;
  localparam int S_DBG_ACT  = 3;
  localparam int S_BUS_PEND = 4;
  localparam int S_BUS_EN   = 5;
  localparam int S_SF_EN    = 6;
  localparam int S_SF_PEND  = 7;

  // Word positions of the clear-only bits
  localparam int POS_HF_ACT  = 2;
  localparam int POS_NMI_ACT = 5;

  // entry_mark encoding
  localparam int M_HF_NS = 0;
  localparam int M_HF_S  = 1;
  localparam int M_NMI   = 2;

  typedef logic [BANK_N-1:0] bank_t;
  typedef logic [SHR_N-1:0]  shr_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic bank_t bank_gather(input word_t w);
    bank_t r;
    for (int i = 0; i < BANK_N; i++) r[i] = w[BANK_POS[i]];
    return r;
  endfunction

  function automatic word_t bank_spread(input bank_t b);
    word_t r;
    r = '0;
    for (int i = 0; i < BANK_N; i++) r[BANK_POS[i]] = b[i];
    return r;
  endfunction

  function automatic shr_t shr_gather(input word_t w);
    shr_t r;
    for (int i = 0; i < SHR_N; i++) r[i] = w[SHR_POS[i]];
    return r;
  endfunction

  function automatic word_t shr_spread(input shr_t s);
    word_t r;
    r = '0;
    for (int i = 0; i < SHR_N; i++) r[SHR_POS[i]] = s[i];
    return r;
  endfunction
endpackage

// File: rtl/hsr_bank.sv
module hsr_bank
  import hsr_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  word_t wdata,
  input  logic  hfa_clr,
  input  logic  hfa_set,
  output bank_t q
);
  bank_t nxt;

  always_comb begin
    nxt = q;
    if (we) begin
      nxt           = bank_gather(wdata);
      nxt[B_HF_ACT] = q[B_HF_ACT];
    end
    if (hfa_clr) nxt[B_HF_ACT] = 1'b0;
    if (hfa_set) nxt[B_HF_ACT] = 1'b1;
    if (LEGACY) begin
      nxt[B_HF_ACT]  = 1'b0;
      nxt[B_HF_PEND] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/hsr_shared.sv
module hsr_shared
  import hsr_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  logic  sec_access,
  input  logic  route_ns,
  input  word_t wdata,
  input  logic  nmi_clr,
  input  logic  nmi_set,
  output shr_t  q
);
  shr_t nxt;
  shr_t wv;

  always_comb begin
    wv  = shr_gather(wdata);
    nxt = q;
    if (wr_en) begin
      nxt[S_DBG_ACT] = wv[S_DBG_ACT];
      if (sec_access || route_ns) begin
        nxt[S_BUS_ACT]  = wv[S_BUS_ACT];
        nxt[S_BUS_PEND] = wv[S_BUS_PEND];
        nxt[S_BUS_EN]   = wv[S_BUS_EN];
      end
      if (sec_access) begin
        nxt[S_SF_ACT]  = wv[S_SF_ACT];
        nxt[S_SF_EN]   = wv[S_SF_EN];
        nxt[S_SF_PEND] = wv[S_SF_PEND];
      end
    end
    if (nmi_clr) nxt[S_NMI_ACT] = 1'b0;
    if (nmi_set) nxt[S_NMI_ACT] = 1'b1;
    if (LEGACY)  nxt[S_NMI_ACT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/hsr_readmux.sv
module hsr_readmux
  import hsr_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic  rd_en,
  input  logic  sec_access,
  input  logic  route_ns,
  input  bank_t s_q,
  input  bank_t ns_q,
  input  shr_t  sh_q,
  output word_t rdata
);
  bank_t bsel;
  shr_t  svis;

  always_comb begin
    bsel = sec_access ? s_q : ns_q;
    svis = sh_q;
    if (!(sec_access || route_ns)) begin
      svis[S_BUS_ACT]  = 1'b0;
      svis[S_BUS_PEND] = 1'b0;
      svis[S_BUS_EN]   = 1'b0;
      svis[S_NMI_ACT]  = 1'b0;
    end
    if (!sec_access) begin
      svis[S_SF_ACT]  = 1'b0;
      svis[S_SF_EN]   = 1'b0;
      svis[S_SF_PEND] = 1'b0;
    end
    if (LEGACY) begin
      bsel[B_HF_ACT]  = 1'b0;
      bsel[B_HF_PEND] = 1'b0;
      svis[S_NMI_ACT] = 1'b0;
    end
    rdata = rd_en ? (bank_spread(bsel) | shr_spread(svis)) : '0;
  end
endmodule

// File: rtl/hsr_banked_status.sv
module hsr_banked_status
  import hsr_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic                    sec_access,
  input  logic                    cpu_secure,
  input  logic                    route_ns,
  input  logic [WORD_W-1:0]       wdata,
  input  logic [MARK_N-1:0]       entry_mark,
  output logic [WORD_W-1:0]       rdata,
  output logic                    upd_pulse,
  output logic [BANK_N-1:0]       s_state,
  output logic [BANK_N-1:0]       ns_state,
  output logic [SHR_N-1:0]        shared_state
);
  localparam int NBANKS = 2;   // index 0 non-secure, 1 secure

  logic  [NBANKS-1:0] bank_we;
  logic  [NBANKS-1:0] bank_clr;
  logic  [NBANKS-1:0] bank_set;
  bank_t              bank_q [NBANKS];
  logic               clr_window;
  logic               hf_clr;
  logic               nmi_clr;

  // Clear-only path: non-secure alias written from secure state with routing on
  assign clr_window = wr_en && !sec_access && cpu_secure && route_ns;
  assign hf_clr     = clr_window && !wdata[POS_HF_ACT];
  assign nmi_clr    = clr_window && !wdata[POS_NMI_ACT];

  assign bank_we  = {wr_en && sec_access, wr_en && !sec_access};
  assign bank_clr = {1'b0, hf_clr};
  assign bank_set = {entry_mark[M_HF_S], entry_mark[M_HF_NS]};

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    hsr_bank #(.LEGACY(LEGACY)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .we      (bank_we[g]),
      .wdata   (wdata),
      .hfa_clr (bank_clr[g]),
      .hfa_set (bank_set[g]),
      .q       (bank_q[g])
    );
  end

  hsr_shared #(.LEGACY(LEGACY)) u_shared (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .sec_access (sec_access),
    .route_ns   (route_ns),
    .wdata      (wdata),
    .nmi_clr    (nmi_clr),
    .nmi_set    (entry_mark[M_NMI]),
    .q          (shared_state)
  );

  hsr_readmux #(.LEGACY(LEGACY)) u_rmux (
    .rd_en      (rd_en),
    .sec_access (sec_access),
    .route_ns   (route_ns),
    .s_q        (bank_q[1]),
    .ns_q       (bank_q[0]),
    .sh_q       (shared_state),
    .rdata      (rdata)
  );

  assign s_state  = bank_q[1];
  assign ns_state = bank_q[0];

  always_ff @(posedge clk) begin
    if (rst) upd_pulse <= 1'b0;
    else     upd_pulse <= wr_en;
  end
endmodule

// File: rtl/hsr_banked_status_chk.sv
module hsr_banked_status_chk
  import hsr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              sec_access,
  input logic              route_ns,
  input logic [WORD_W-1:0] rdata,
  input logic [MARK_N-1:0] entry_mark,
  input logic              upd_pulse,
  input logic [BANK_N-1:0] s_state,
  input logic [BANK_N-1:0] ns_state,
  input logic [SHR_N-1:0]  shared_state
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $fell(rst) |-> (s_state == '0 && ns_state == '0 && shared_state == '0 && !upd_pulse));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && entry_mark == '0) |=> ($stable(s_state) && $stable(ns_state) && $stable(shared_state)));

  assert_ns_sf_hidden_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sec_access) |-> (rdata[4] == 1'b0 && rdata[19] == 1'b0 && rdata[20] == 1'b0));

  assert_bus_nmi_hidden_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sec_access && !route_ns) |->
      (rdata[1] == 1'b0 && rdata[5] == 1'b0 && rdata[14] == 1'b0 && rdata[17] == 1'b0));

  assert_s_hfact_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sec_access && !entry_mark[M_HF_S]) |=> (s_state[B_HF_ACT] == $past(s_state[B_HF_ACT])));

  assert_ns_hfact_no_set_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ns_state[B_HF_ACT]) |-> $past(entry_mark[M_HF_NS]));

  assert_nmi_no_set_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(shared_state[S_NMI_ACT]) |-> $past(entry_mark[M_NMI]));

  assert_pulse_follows_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> upd_pulse);

  assert_pulse_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !upd_pulse);

  assert_read_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rdata == '0));
endmodule

bind hsr_banked_status hsr_banked_status_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .sec_access   (sec_access),
  .route_ns     (route_ns),
  .rdata        (rdata),
  .entry_mark   (entry_mark),
  .upd_pulse    (upd_pulse),
  .s_state      (s_state),
  .ns_state     (ns_state),
  .shared_state (shared_state)
);

// File: tb/test_hsr_banked_status.sv
module test_hsr_banked_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        sec_access = 1'b0;
  logic        cpu_secure = 1'b0;
  logic        route_ns = 1'b0;
  logic [31:0] wdata = '0;
  logic [2:0]  entry_mark = '0;
  logic [31:0] rdata, rdata_l;
  logic        upd_pulse, upd_l;
  logic [11:0] s_state, ns_state, s_l, ns_l;
  logic [7:0]  shared_state, sh_l;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic last_upd;

  localparam logic [31:0] M_BANKED = 32'h0025_BC8D;
  localparam logic [31:0] M_HFACT  = 32'h0000_0004;
  localparam logic [31:0] M_SF     = 32'h0018_0010;
  localparam logic [31:0] M_BUS    = 32'h0002_4002;
  localparam logic [31:0] M_NMI    = 32'h0000_0020;
  localparam logic [31:0] M_DBG    = 32'h0000_0100;
  localparam logic [31:0] M_LEG    = 32'h0020_0024;

  always #2 clk = ~clk;   // 250 MHz

  hsr_banked_status i_hsr_banked_status (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sec_access(sec_access),
    .cpu_secure(cpu_secure), .route_ns(route_ns), .wdata(wdata), .entry_mark(entry_mark),
    .rdata(rdata), .upd_pulse(upd_pulse), .s_state(s_state), .ns_state(ns_state),
    .shared_state(shared_state)
  );

  hsr_banked_status #(.LEGACY(1'b1)) i_legacy (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sec_access(sec_access),
    .cpu_secure(cpu_secure), .route_ns(route_ns), .wdata(wdata), .entry_mark(entry_mark),
    .rdata(rdata_l), .upd_pulse(upd_l), .s_state(s_l), .ns_state(ns_l),
    .shared_state(sh_l)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input bit s, input bit c, input bit r, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; sec_access = s; cpu_secure = c; route_ns = r; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    last_upd = upd_pulse;
  endtask

  task automatic rd(input bit s, input bit r, output logic [31:0] v, output logic [31:0] vl);
    sec_access = s; route_ns = r; rd_en = 1'b1;
    #1;
    v = rdata; vl = rdata_l;
    rd_en = 1'b0;
  endtask

  task automatic mark(input logic [2:0] m);
    @(negedge clk); entry_mark = m;
    @(negedge clk); entry_mark = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v, vl;
    do_reset();
    check("R1 s_state", {20'd0, s_state}, 32'd0);
    check("R1 ns_state", {20'd0, ns_state}, 32'd0);
    check("R1 shared_state", {24'd0, shared_state}, 32'd0);
    check("R1 upd_pulse", {31'd0, upd_pulse}, 32'd0);
    rd(1, 1, v, vl);
    check("R1 read", v, 32'd0);
  endtask

  task automatic t_banking();
    logic [31:0] v, vl;
    do_reset();
    wr(1, 0, 0, M_BANKED);
    rd(1, 0, v, vl);
    check("R2/R5 secure copy", v, M_BANKED & ~M_HFACT);
    rd(0, 0, v, vl);
    check("R2 ns copy untouched", v, 32'd0);
    wr(0, 0, 0, M_BANKED);
    rd(0, 0, v, vl);
    check("R2/R7 ns copy written", v, M_BANKED & ~M_HFACT);
    check("R7 ns hf pending", {31'd0, ns_state[11]}, 32'd1);
    wr(0, 0, 0, 32'd0);
    rd(0, 0, v, vl);
    check("R7 ns copy cleared", v, 32'd0);
    rd(1, 0, v, vl);
    check("R2 secure copy kept", v, M_BANKED & ~M_HFACT);
  endtask

  task automatic t_secure_fault();
    logic [31:0] v, vl;
    do_reset();
    wr(1, 0, 0, M_SF);
    rd(1, 0, v, vl);
    check("R3 secure sees sf", v, M_SF);
    rd(0, 1, v, vl);
    check("R3 ns sees no sf", v, 32'd0);
    wr(0, 0, 1, 32'hFFFF_FFFF);
    rd(1, 1, v, vl);
    check("R3 sf kept after ns write", v, M_SF | M_BUS | M_DBG);
    rd(0, 1, v, vl);
    check("R3 ns view", v, (M_BANKED & ~M_HFACT) | M_BUS | M_DBG);
    wr(0, 0, 1, 32'd0);
    rd(1, 1, v, vl);
    check("R3 ns clear ignored", v, M_SF);
  endtask

  task automatic t_bus();
    logic [31:0] v, vl;
    do_reset();
    wr(1, 0, 0, M_BUS);
    rd(1, 0, v, vl);
    check("R4 secure read", v, M_BUS);
    rd(0, 0, v, vl);
    check("R4 hidden without route", v, 32'd0);
    rd(0, 1, v, vl);
    check("R4 visible with route", v, M_BUS);
    wr(0, 0, 0, 32'd0);
    rd(1, 0, v, vl);
    check("R4 ns write ignored", v, M_BUS);
    wr(0, 0, 1, 32'd0);
    rd(1, 0, v, vl);
    check("R4 ns write with route", v, 32'd0);
  endtask

  task automatic t_clear_only();
    logic [31:0] v, vl;
    do_reset();
    mark(3'b111);
    check("R11 marks set", {29'd0, ns_state[1], s_state[1], shared_state[1]}, 32'd7);
    rd(0, 1, v, vl);
    check("R11 ns read", v, M_HFACT | M_NMI);
    check("R12 legacy hidden", vl, 32'd0);
    rd(0, 0, v, vl);
    check("R4 nmi hidden", v, M_HFACT);
    wr(1, 1, 1, 32'd0);
    rd(1, 1, v, vl);
    check("R5 secure write keeps hf/nmi", v, M_HFACT | M_NMI);
    wr(0, 0, 1, 32'd0);
    rd(0, 1, v, vl);
    check("R6 no clear, cpu non-secure", v, M_HFACT | M_NMI);
    wr(0, 1, 0, 32'd0);
    rd(0, 1, v, vl);
    check("R6 no clear, route off", v, M_HFACT | M_NMI);
    wr(0, 1, 1, M_HFACT | M_NMI);
    rd(0, 1, v, vl);
    check("R6 no clear, ones written", v, M_HFACT | M_NMI);
    wr(0, 1, 1, 32'd0);
    rd(0, 1, v, vl);
    check("R6 cleared", v, 32'd0);
    rd(1, 1, v, vl);
    check("R6 secure hf kept", v, M_HFACT);
    wr(0, 1, 1, M_HFACT | M_NMI);
    rd(0, 1, v, vl);
    check("R6 never set", v, 32'd0);
  endtask

  task automatic t_debug_pulse();
    logic [31:0] v, vl;
    do_reset();
    wr(0, 0, 0, M_DBG);
    check("R9 pulse after write", {31'd0, last_upd}, 32'd1);
    rd(1, 0, v, vl);
    check("R8 secure sees debug", v, M_DBG);
    @(negedge clk);
    check("R9 pulse one cycle", {31'd0, upd_pulse}, 32'd0);
    wr(1, 0, 0, 32'd0);
    rd(0, 0, v, vl);
    check("R8 secure clear seen by ns", v, 32'd0);
  endtask

  task automatic t_read_legacy();
    logic [31:0] v, vl;
    do_reset();
    wr(1, 0, 1, 32'hFFFF_FFFF);
    rd(1, 1, v, vl);
    check("R10 all-ones secure", v, (M_BANKED & ~M_HFACT) | M_BUS | M_SF | M_DBG);
    check("R10 unused zero", v & ~(M_BANKED | M_BUS | M_SF | M_DBG | M_NMI), 32'd0);
    sec_access = 1'b1; route_ns = 1'b1; rd_en = 1'b0;
    #1;
    check("R10 no strobe", rdata, 32'd0);
    wr(0, 0, 1, 32'hFFFF_FFFF);
    mark(3'b111);
    rd(0, 1, v, vl);
    check("R7 main hf pending", v & M_LEG, M_LEG);
    check("R12 legacy bits zero", vl & M_LEG, 32'd0);
    check("R12 legacy others", vl & ~M_LEG, v & ~M_LEG);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_banking();
    t_secure_fault();
    t_bus();
    t_clear_only();
    t_debug_pulse();
    t_read_legacy();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule